// File: doc/BRIEF.md
# Per-Pin Interrupt Detect Unit

This block watches the synchronized levels of a port of up to 32 pins and raises interrupt flags when a pin shows the condition its own mode selects. Each pin has one control word on a small register port. A 4-bit mode field in that word picks one of six behaviours: off, a low or high level, a rising edge, a falling edge, or any edge.

Detected conditions set bits in a shared status word, one bit per pin. Software clears those bits by writing ones to them. One registered interrupt line is high while any status bit is set, so a handler reads the status word, services the pins whose bits are set, and writes those bits back to acknowledge them. The register port writes in one cycle and reads combinationally.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset every mode field, every status bit and the interrupt output are 0.
- R2: The control word of pin n sits at byte address 4*n. Its mode field is bits 19:16, and those bits read back as written. All other bits of the control word read as 0.
- R3: Mode 0x0 and every encoding not named in R4 to R8 leave the pin's status bit unset. Writing 0 to a control word turns detection off for that pin.
- R4: In mode 0x9, a pin whose sample goes from 0 to 1 sets its status bit on the next clock. A falling edge does not set it.
- R5: In mode 0xA, a pin whose sample goes from 1 to 0 sets its status bit on the next clock. A rising edge does not set it.
- R6: In mode 0xB, a pin whose sample changes in either direction sets its status bit on the next clock.
- R7: In mode 0x8, the status bit is set on every clock in which the pin is 0.
- R8: In mode 0xC, the status bit is set on every clock in which the pin is 1.
- R9: The status word is at byte address 0xA0, with bit n belonging to pin n. Writing 1 to a bit clears it, and writing 0 to a bit leaves it unchanged.
- R10: When a detected condition and a clear of the same status bit happen in the same cycle, the bit stays set.
- R11: The interrupt output is the OR of all status bits, registered. It rises and falls one clock after the status word changes between empty and non-empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| pins | input | 32 | Synchronized pin levels |
| irq | output | 1 | Combined interrupt line |

## Verification
The hardest case to reach from the ports is a clear that collides with a detection in the same cycle. The bench sets up this collision with the level modes: it holds a pin at its active level and then writes a one to that pin's status bit, so the detection and the clear land on the same clock edge, and the bit is expected to stay set. The one-cycle lag of the interrupt line is checked on both its rising and its falling edge. The stimulus changes a pin or clears the whole status word, then samples the line on two successive cycles.

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
  parameter int NPINS     = 32,
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int MODE_LSB  = 16,
  parameter logic [7:0] STAT_ADDR = 8'hA0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NPINS-1:0] pins,
  output logic             irq
);
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [3:0] M_LOW  = 4'h8;
  localparam logic [3:0] M_RISE = 4'h9;
  localparam logic [3:0] M_FALL = 4'hA;
  localparam logic [3:0] M_ANY  = 4'hB;
  localparam logic [3:0] M_HIGH = 4'hC;

  logic [NPINS-1:0][3:0] mode_q;
  logic [NPINS-1:0]      prev_q, flag_q, hit;
  logic                  irq_q;

  wire             stat_sel = (addr == AW'(STAT_ADDR));
  wire             ctrl_sel = (addr[1:0] == 2'b00) && (int'(addr[AW-1:2]) < NPINS);
  wire [IDX_W-1:0] idx      = IDX_W'(addr[AW-1:2]);
  wire [NPINS-1:0] clr      = (wr_en && stat_sel) ? wdata[NPINS-1:0] : '0;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_comb begin
      case (mode_q[i])
        M_LOW:   hit[i] = ~pins[i];
        M_RISE:  hit[i] = pins[i] & ~prev_q[i];
        M_FALL:  hit[i] = ~pins[i] & prev_q[i];
        M_ANY:   hit[i] = pins[i] ^ prev_q[i];
        M_HIGH:  hit[i] = pins[i];
        default: hit[i] = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        mode_q[i] <= '0;
      else if (wr_en && ctrl_sel && idx == IDX_W'(i))
        mode_q[i] <= wdata[MODE_LSB +: 4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= pins;
      flag_q <= (flag_q & ~clr) | hit;
      irq_q  <= |flag_q;
    end
  end

  always_comb begin
    rdata = '0;
    if (stat_sel)
      rdata[NPINS-1:0] = flag_q;
    else if (ctrl_sel)
      rdata[MODE_LSB +: 4] = mode_q[idx];
  end

  assign irq = irq_q;
endmodule

// File: rtl/pin_irq_detect_chk.sv
module pin_irq_detect_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter logic [7:0] STAT_ADDR = 8'hA0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [AW-1:0]         addr,
  input logic [DW-1:0]         wdata,
  input logic [NPINS-1:0]      pins,
  input logic [NPINS-1:0]      flags,
  input logic [NPINS-1:0]      prev,
  input logic [NPINS-1:0][3:0] modes,
  input logic                  irq
);
  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    wire live = modes[i] inside {4'h8, 4'h9, 4'hA, 4'hB, 4'hC};

    p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      modes[i] == 4'h9 && pins[i] && !prev[i] |=> flags[i]);
    p_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      modes[i] == 4'hA && !pins[i] && prev[i] |=> flags[i]);
    p_any_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      modes[i] == 4'hB && pins[i] != prev[i] |=> flags[i]);
    p_level_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      modes[i] == 4'h8 && !pins[i] |=> flags[i]);
    p_level_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      modes[i] == 4'hC && pins[i] |=> flags[i]);
    p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !live && !flags[i] |=> !flags[i]);
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == AW'(STAT_ADDR) && wdata[i] && !live |=> !flags[i]);
  end

  p_irq_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags) |=> irq);
  p_irq_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|flags) |=> !irq);
endmodule

bind pin_irq_detect pin_irq_detect_chk #(
  .NPINS(NPINS), .AW(AW), .DW(DW), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pins(pins), .flags(flag_q), .prev(prev_q), .modes(mode_q), .irq(irq)
);

// File: tb/pin_irq_detect_bench.sv
module pin_irq_detect_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pins = '0;
  logic        irq;
  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  pin_irq_detect u_pin_irq_detect (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pins(pins), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic tidy();
    for (int i = 0; i < 32; i++) wr(8'(4*i), 32'h0);
    wr(8'hA0, 32'hFFFF_FFFF);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 ctrl0", v, 0);
    rd(8'h7C, v); chk("R1 ctrl31", v, 0);
    rd(8'hA0, v); chk("R1 status", v, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, v); chk("R2 field only", v, 32'h000F_0000);
    wr(8'h7C, 32'h0009_0000); rd(8'h7C, v); chk("R2 pin31", v, 32'h0009_0000);
    rd(8'h14, v); chk("R2 pin5 kept", v, 32'h000F_0000);
    tidy();
  endtask

  task automatic t_rise();
    logic [31:0] v;
    wr(8'h0C, 32'h0009_0000);
    @(negedge clk) pins[3] = 1'b1;
    rd(8'hA0, v); chk("R4 rise sets", v, 32'h8);
    chk("R11 irq lags", 32'(irq), 0);
    @(negedge clk); chk("R11 irq rises", 32'(irq), 1);
    wr(8'hA0, 32'h8);
    @(negedge clk) pins[3] = 1'b0;
    rd(8'hA0, v); chk("R4 fall ignored", v, 0);
    tidy();
  endtask

  task automatic t_fall();
    logic [31:0] v;
    wr(8'h10, 32'h000A_0000);
    @(negedge clk) pins[4] = 1'b1;
    rd(8'hA0, v); chk("R5 rise ignored", v, 0);
    @(negedge clk) pins[4] = 1'b0;
    rd(8'hA0, v); chk("R5 fall sets", v, 32'h10);
    tidy();
  endtask

  task automatic t_any();
    logic [31:0] v;
    wr(8'h18, 32'h000B_0000);
    @(negedge clk) pins[6] = 1'b1;
    rd(8'hA0, v); chk("R6 rise sets", v, 32'h40);
    wr(8'hA0, 32'h40);
    rd(8'hA0, v); chk("R6 cleared", v, 0);
    @(negedge clk) pins[6] = 1'b0;
    rd(8'hA0, v); chk("R6 fall sets", v, 32'h40);
    tidy();
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(8'h1C, 32'h0008_0000);
    rd(8'hA0, v); chk("R7 low sets", v, 32'h80);
    wr(8'hA0, 32'h80);
    rd(8'hA0, v); chk("R10 set beats clear low", v, 32'h80);
    @(negedge clk) pins[7] = 1'b1;
    wr(8'hA0, 32'h80);
    rd(8'hA0, v); chk("R7 released clears", v, 0);
    wr(8'h1C, 32'h0);
    pins[8] = 1'b1;
    wr(8'h20, 32'h000C_0000);
    rd(8'hA0, v); chk("R8 high sets", v, 32'h100);
    wr(8'hA0, 32'h100);
    rd(8'hA0, v); chk("R10 set beats clear high", v, 32'h100);
    @(negedge clk) pins[8] = 1'b0;
    wr(8'hA0, 32'h100);
    rd(8'hA0, v); chk("R8 released clears", v, 0);
    pins[7] = 1'b0;
    tidy();
  endtask

  task automatic t_off();
    logic [31:0] v;
    wr(8'h24, 32'h0001_0000);
    wr(8'h28, 32'h000F_0000);
    wr(8'h2C, 32'h000D_0000);
    @(negedge clk) pins[11:9] = 3'b111;
    @(negedge clk) pins[11:9] = 3'b000;
    rd(8'hA0, v); chk("R3 odd codes quiet", v, 0);
    wr(8'h30, 32'h000C_0000);
    wr(8'h30, 32'h0);
    wr(8'hA0, 32'h1000);
    @(negedge clk) pins[12] = 1'b1;
    rd(8'hA0, v); chk("R3 write 0 disables", v, 0);
    chk("R3 irq quiet", 32'(irq), 0);
    pins[12] = 1'b0;
    tidy();
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(8'h0C, 32'h0009_0000);
    wr(8'h18, 32'h000B_0000);
    @(negedge clk) begin pins[3] = 1'b1; pins[6] = 1'b1; end
    rd(8'hA0, v); chk("R9 two set", v, 32'h48);
    wr(8'hA0, 32'h0);
    rd(8'hA0, v); chk("R9 zeros no effect", v, 32'h48);
    wr(8'hA0, 32'h8);
    rd(8'hA0, v); chk("R9 one bit cleared", v, 32'h40);
    wr(8'hA0, 32'hFFFF_FFFF);
    chk("R11 irq still high", 32'(irq), 1);
    @(negedge clk); chk("R11 irq drops", 32'(irq), 0);
    rd(8'hA0, v); chk("R9 all cleared", v, 0);
    pins[3] = 1'b0; pins[6] = 1'b0;
    tidy();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog got=%0d exp=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_rise();
    t_fall();
    t_any();
    t_level();
    t_off();
    t_w1c();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule